// File: doc/BRIEF.md
# Stop-Mode Wake-Up Sequencer

This block sits beside a small 8-bit processor core and runs its low-power stop state. When the core signals that it has executed a stop instruction, and software has not set the stay-awake bit in the clock-control register, the sequencer drops the core clock enable. It saves the address of the instruction that follows the stop, and it then freezes every control register. The clock enable stands in for the oscillator, which is not part of this block.

The sequencer leaves the stop state in one of two ways. The first is a hardware reset, which returns all control state to its reset values. The second is an external interrupt request whose own enable bit is set. After an interrupt wake-up, a stabilization timer starts at zero. It advances once every 2^(n+3) clock cycles, where n is the prescale field captured at stop entry. The timer must overflow past its all-ones value before the clock comes back.

When the timer overflows, the sequencer emits a one-cycle resume pulse. With that pulse it gives a flag that tells the core what to do next: take the interrupt vector when the master interrupt flag is 1, or carry on at the saved address when the flag is 0. Interrupts that arrive during stabilization are recorded, and they do not restart the wait.

All pins are plain control and status pins. No data stream passes through the block, so no valid/ready handshake is used and there is no back-pressure.

Top module: `stop_wake_seq`

## Requirements
- R1: A stop strobe during normal running enters the stop state only when control bit 3 (stay-awake) is 0. With that bit at 1, the strobe is ignored and clk_en stays 1.
- R2: While stopped or stabilizing, clk_en is 0 and stopped is 1. Control-register writes are ignored outside normal running, so the readback does not change.
- R3: A request wakes the block only when irq_req[i] and irq_en[i] are both 1 for some source i. A request on a source whose enable bit is 0 leaves the block stopped.
- R4: After a wake-up, stabilization lasts exactly 256 * 2^(n+3) cycles, where n is control bits [2:0] at stop entry. It is followed by a single-cycle resume_pulse with clk_en at 1.
- R5: vector_take during resume_pulse equals the master_ie value held in the last stabilization cycle.
- R6: saved_pc takes the pc_next value present with the accepted stop strobe, and it holds that value through the stop.
- R7: An active-low reset in any state returns the block to normal running immediately. After reset, clk_en is 1, the control register is 0x00 and saved_pc is 0.
- R8: An enabled request that arrives during stabilization does not restart or lengthen the wait. wake_src at resume holds the OR of every enabled request seen from the release up to the resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_strobe | input | 1 | Core executed a stop instruction |
| pc_next | input | 16 | Address of the instruction after the stop |
| ctl_wr | input | 1 | Control-register write strobe |
| ctl_wdata | input | 8 | Control write data: [2:0] prescale n, [3] stay-awake |
| ctl_rdata | output | 8 | Control-register readback |
| irq_req | input | 4 | External interrupt requests |
| irq_en | input | 4 | Per-source interrupt enables |
| master_ie | input | 1 | Master interrupt flag |
| clk_en | output | 1 | Core clock enable |
| stopped | output | 1 | High in the stop and stabilization states |
| resume_pulse | output | 1 | One-cycle end-of-stabilization pulse |
| vector_take | output | 1 | With resume_pulse: 1 means take the vector |
| wake_src | output | 4 | Enabled requests seen since the release |
| saved_pc | output | 16 | Resume address captured at stop entry |

## Verification
The bench sweeps the prescale setting from 0 to 4 and counts the stabilization cycles one by one. An off-by-one in the divider or the timer would show up as a count that is one tick too long or too short. Whenever the block is stopped, every request pattern that has no enabled source is driven in turn. A design that used the raw requests without masking would wake early. A second request is injected in the middle of one stabilization window; a design that restarted the timer would produce a longer window. The bench also writes the control register while stopped, sets the stay-awake bit and applies reset during stabilization. These cases catch writes that leak through, stop entry that ignores the stay-awake bit, and reset that leaves the clock gated.

// File: rtl/swk_pkg.sv
package swk_pkg;
  typedef enum logic [1:0] {
    S_RUN    = 2'd0,
    S_STOP   = 2'd1,
    S_STAB   = 2'd2,
    S_RESUME = 2'd3
  } swk_state_e;

  localparam int CTL_W      = 8;
  localparam int SEL_W      = 3;
  localparam int STAY_BIT   = 3;
endpackage

// File: rtl/swk_ctlreg.sv
module swk_ctlreg
  import swk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic              wr,
  input  logic [CTL_W-1:0]  wdata,
  output logic [CTL_W-1:0]  q,
  output logic [SEL_W-1:0]  sel,
  output logic              stay
);
  logic [CTL_W-1:0] q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          q_r <= '0;
    else if (wr && wr_ok) q_r <= wdata;
  end

  assign q    = q_r;
  assign sel  = q_r[SEL_W-1:0];
  assign stay = q_r[STAY_BIT];

  // R2
  frozen_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ok |=> $stable(q_r));
endmodule

// File: rtl/swk_stab_timer.sv
module swk_stab_timer
  import swk_pkg::*;
#(
  parameter int TMR_W = 8
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             done
);
  localparam int PW = (1 << SEL_W) + 3;
  localparam logic [TMR_W-1:0] TMAX = '1;

  logic [PW-1:0]    div_q;
  logic [TMR_W-1:0] tmr_q;
  logic [PW-1:0]    lim;
  logic             tick;

  assign lim  = PW'((64'd1 << (int'(sel) + 3)) - 64'd1);
  assign tick = run && (div_q == lim);
  assign done = tick && (tmr_q == TMAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      tmr_q <= '0;
    end else if (clr) begin
      div_q <= '0;
      tmr_q <= '0;
    end else if (run) begin
      if (tick) begin
        div_q <= '0;
        tmr_q <= tmr_q + 1'b1;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  // R8
  stab_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && !done) |=> (tmr_q == $past(tmr_q)) || (tmr_q == TMR_W'($past(tmr_q) + 1'b1)));

  // R4
  stab_from_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (tmr_q == '0 && div_q == '0));
endmodule

// File: rtl/stop_wake_seq.sv
module stop_wake_seq
  import swk_pkg::*;
#(
  parameter int NUM_IRQ = 4,
  parameter int PC_W    = 16,
  parameter int TMR_W   = 8
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stop_strobe,
  input  logic [PC_W-1:0]    pc_next,
  input  logic               ctl_wr,
  input  logic [CTL_W-1:0]   ctl_wdata,
  output logic [CTL_W-1:0]   ctl_rdata,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic               master_ie,
  output logic               clk_en,
  output logic               stopped,
  output logic               resume_pulse,
  output logic               vector_take,
  output logic [NUM_IRQ-1:0] wake_src,
  output logic [PC_W-1:0]    saved_pc
);
  swk_state_e       state_q;
  logic [SEL_W-1:0] sel_live, sel_q;
  logic             stay;
  logic             stab_done;
  logic             vt_q;
  logic [PC_W-1:0]  pc_q;
  logic [NUM_IRQ-1:0] hit_vec;
  logic             hit;
  logic             enter;
  logic             running;
  logic             wsrc_q [NUM_IRQ];

  assign running = (state_q == S_RUN);
  assign hit_vec = irq_req & irq_en;
  assign hit     = |hit_vec;
  assign enter   = running && stop_strobe && !stay;

  swk_ctlreg u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_ok (running),
    .wr    (ctl_wr),
    .wdata (ctl_wdata),
    .q     (ctl_rdata),
    .sel   (sel_live),
    .stay  (stay)
  );

  swk_stab_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state_q == S_STOP),
    .run   (state_q == S_STAB),
    .sel   (sel_q),
    .done  (stab_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_RUN;
      sel_q   <= '0;
      pc_q    <= '0;
      vt_q    <= 1'b0;
    end else begin
      case (state_q)
        S_RUN: if (enter) begin
          state_q <= S_STOP;
          pc_q    <= pc_next;
          sel_q   <= sel_live;
        end
        S_STOP:   if (hit) state_q <= S_STAB;
        S_STAB: if (stab_done) begin
          state_q <= S_RESUME;
          vt_q    <= master_ie;
        end
        default:  state_q <= S_RUN;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                        wsrc_q[i] <= 1'b0;
      else if (enter)                                    wsrc_q[i] <= 1'b0;
      else if (state_q == S_STOP || state_q == S_STAB)   wsrc_q[i] <= wsrc_q[i] | hit_vec[i];
    end
    assign wake_src[i] = wsrc_q[i];
  end

  assign stopped      = (state_q == S_STOP) || (state_q == S_STAB);
  assign clk_en       = !stopped;
  assign resume_pulse = (state_q == S_RESUME);
  assign vector_take  = resume_pulse && vt_q;
  assign saved_pc     = pc_q;

  // R4
  resume_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_pulse |=> (!resume_pulse && clk_en));

  // R3
  masked_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_STOP && !hit) |=> stopped && !resume_pulse);

  // R6
  pc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter |=> saved_pc == $past(pc_next));

  // R5
  vector_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resume_pulse) |-> vector_take == $past(master_ie));

  // R1
  stay_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && stay) |=> clk_en);
endmodule

// File: tb/tb_stop_wake_seq.sv
module tb_stop_wake_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stop_strobe = 1'b0;
  logic [15:0] pc_next = '0;
  logic        ctl_wr = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic [7:0]  ctl_rdata;
  logic [3:0]  irq_req = '0;
  logic [3:0]  irq_en = '0;
  logic        master_ie = 1'b0;
  logic        clk_en, stopped, resume_pulse, vector_take;
  logic [3:0]  wake_src;
  logic [15:0] saved_pc;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  stop_wake_seq dut (
    .clk(clk), .rst_n(rst_n), .stop_strobe(stop_strobe), .pc_next(pc_next),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .irq_req(irq_req), .irq_en(irq_en), .master_ie(master_ie),
    .clk_en(clk_en), .stopped(stopped), .resume_pulse(resume_pulse),
    .vector_take(vector_take), .wake_src(wake_src), .saved_pc(saved_pc)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic do_stop(input logic [15:0] pc);
    stop_strobe = 1'b1; pc_next = pc;
    @(negedge clk);
    stop_strobe = 1'b0; pc_next = 16'hDEAD;
  endtask

  initial begin
    #(8 * 180000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state
    check(clk_en && !stopped && !resume_pulse, "R7 reset clk_en", clk_en, 1);
    check(ctl_rdata == 8'h00, "R7 reset ctl", ctl_rdata, 0);
    check(saved_pc == 16'h0, "R7 reset pc", saved_pc, 0);

    // R1 stay-awake blocks stop
    wr_ctl(8'h08);
    check(ctl_rdata == 8'h08, "R1 ctl write", ctl_rdata, 8);
    do_stop(16'h0222);
    check(clk_en && !stopped, "R1 stay-awake", stopped, 0);
    repeat (3) @(negedge clk);
    check(clk_en, "R1 still running", clk_en, 1);

    for (int n = 0; n < 5; n++) begin
      logic [3:0] en1;
      logic [3:0] other;
      logic [3:0] exp_src;
      int cnt;
      int exp_len;
      en1 = 4'b0001 << (n % 4);
      other = 4'b0001 << ((n + 1) % 4);
      exp_len = 256 * (8 << n) + 1;
      exp_src = (n == 2) ? (en1 | other) : en1;
      wr_ctl({5'b10100, 3'(n)});
      do_stop(16'h1000 + 16'(n * 3));
      // R2 gated clock
      check(stopped && !clk_en, "R2 stopped", clk_en, 0);
      // R6 captured address
      check(saved_pc == 16'h1000 + 16'(n * 3), "R6 saved_pc", saved_pc, 16'h1000 + n * 3);
      // R2 write ignored while stopped
      wr_ctl(8'hFF);
      check(ctl_rdata == {5'b10100, 3'(n)}, "R2 write ignored", ctl_rdata, {5'b10100, 3'(n)});
      // R3 every masked pattern is ignored
      irq_en = en1;
      for (int p = 0; p < 16; p++) begin
        if ((4'(p) & en1) == 4'b0) begin
          irq_req = 4'(p);
          @(negedge clk);
          check(stopped && !resume_pulse, "R3 masked request", stopped, 1);
        end
      end
      irq_req = en1;
      master_ie = n[0];
      cnt = 0;
      while (cnt < 300000) begin
        @(negedge clk);
        cnt++;
        if (cnt == 1) irq_req = 4'b0;
        if (n == 2 && cnt == 100) begin irq_en = 4'hF; irq_req = other; end
        if (n == 2 && cnt == 101) begin irq_req = 4'b0; irq_en = en1; end
        if (resume_pulse) break;
        if (clk_en) begin
          check(0, "R2 clk_en during stabilization", clk_en, 0);
          break;
        end
      end
      // R4 and R8 window length
      check(cnt == exp_len, "R4/R8 stabilization length", cnt, exp_len);
      check(resume_pulse && clk_en, "R4 resume pulse", resume_pulse, 1);
      // R5 vector decision
      check(vector_take == n[0], "R5 vector_take", vector_take, n[0]);
      // R8 recorded sources
      check(wake_src == exp_src, "R8 wake_src", wake_src, exp_src);
      check(saved_pc == 16'h1000 + 16'(n * 3), "R6 held pc", saved_pc, 16'h1000 + n * 3);
      @(negedge clk);
      check(!resume_pulse && clk_en && !stopped, "R4 single pulse", resume_pulse, 0);
    end

    // R7 reset during stabilization
    wr_ctl(8'h50);
    do_stop(16'h4444);
    irq_en = 4'b0010; irq_req = 4'b0010;
    @(negedge clk);
    irq_req = 4'b0;
    repeat (50) @(negedge clk);
    check(stopped, "R7 stabilizing before reset", stopped, 1);
    rst_n = 1'b0;
    #1;
    check(clk_en && !stopped, "R7 async reset clk_en", clk_en, 1);
    @(negedge clk);
    check(ctl_rdata == 8'h00 && saved_pc == 16'h0, "R7 reset clears ctl", ctl_rdata, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(clk_en && !resume_pulse, "R7 running after reset", clk_en, 1);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule